// File: doc/BRIEF.md
# ECC Event Status and Interrupt Reporter

This block collects error-correction events from two memory sources, a RAM and a flash. Each source can signal a corrected single-bit error or an uncorrectable error. Software chooses which of the four event categories are reported by writing an enable register. When an enabled event arrives, the block sets one status flag, captures the failing address and the access attributes of that event, and raises grouped interrupt requests. The groups are single-bit, RAM uncorrectable, flash uncorrectable, any uncorrectable, and any event.

Only one status flag can be set at a time. A newer enabled event replaces the older flag and its capture registers in one update, so the flag always describes the address and attributes held in the capture registers. Software clears a flag by writing 1 to it. To confirm it read a coherent set, software can read status, then the capture registers, then status again, and compare the two status reads.

The register bus is a simple one. A write takes effect on the clock edge. Read data is a combinational function of the register address and the stored state.

Top module: `ecc_evt_reporter`

## Requirements
- R1: After reset, the enable, status, address-capture and attribute-capture registers all read zero, and every interrupt output is low.
- R2: The registers sit at these offsets: 0 is enable, 1 is status, 2 is captured address, 3 is captured attributes. The enable and status registers use only bits 3:0. Bits 31:4 of both read as zero, and writes to those bits are ignored.
- R3: Category bit positions are the same in enable and status: bit 0 is RAM corrected, bit 1 is flash corrected, bit 2 is RAM uncorrectable, bit 3 is flash uncorrectable. An enabled event sets its bit, and the bit is visible one clock after the strobe is sampled.
- R4: An event whose category bit is clear in the enable register changes neither the status nor the capture registers.
- R5: irq_single is high exactly when (enable bit 0 AND flag bit 0) OR (enable bit 1 AND flag bit 1) is true.
- R6: irq_ram_unc is enable bit 2 AND flag bit 2. irq_fls_unc is enable bit 3 AND flag bit 3. irq_unc is the OR of these two.
- R7: irq_any is the OR of irq_single and irq_unc.
- R8: At most one status flag is set. An enabled event that arrives while another flag is set clears the old flag and sets the new one in the same update.
- R9: The captured address and attributes are loaded from the source that wins, in the same clock as its flag is set.
- R10: Writing 1 to a set status bit clears it. Writing 0, or writing 1 to a bit that is clear, changes nothing.
- R11: If an enabled event and a status clear write fall in the same cycle, the event wins. Its flag is set and its capture is loaded.
- R12: If several enabled events arrive in one cycle, only one is recorded, chosen in this order: RAM uncorrectable, flash uncorrectable, RAM corrected, flash corrected.
- R13: Reading status, then the address, then the attributes, then status again gives two equal status values when no event occurs in between. An enabled event injected between the two status reads makes them differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ram_cor_evt | input | 1 | RAM corrected single-bit event strobe |
| ram_unc_evt | input | 1 | RAM uncorrectable event strobe |
| ram_evt_addr | input | 32 | Address of the RAM event |
| ram_evt_attr | input | 8 | Access attributes of the RAM event |
| fls_cor_evt | input | 1 | Flash corrected single-bit event strobe |
| fls_unc_evt | input | 1 | Flash uncorrectable event strobe |
| fls_evt_addr | input | 32 | Address of the flash event |
| fls_evt_attr | input | 8 | Access attributes of the flash event |
| irq_single | output | 1 | Single-bit correction interrupt |
| irq_ram_unc | output | 1 | RAM uncorrectable interrupt |
| irq_fls_unc | output | 1 | Flash uncorrectable interrupt |
| irq_unc | output | 1 | Any uncorrectable interrupt |
| irq_any | output | 1 | Overall ECC interrupt |

## Verification
An event strobe or a register write sampled at a rising edge is stored in that edge. The register read-back and all five interrupt outputs show the new state right after that edge, so every result is due one cycle after its stimulus. The bench drives inputs on the falling edge. At the next rising edge it updates its model, and on the following falling edge it compares all four registers and all interrupts. A change to the enable register applies only to events sampled after the write edge, and the model follows the same rule.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int NUM_CAT = 4;
  localparam int DATA_W  = 32;

  // category bit positions shared by enable and status
  localparam int CAT_RAM_COR = 0;
  localparam int CAT_FLS_COR = 1;
  localparam int CAT_RAM_UNC = 2;
  localparam int CAT_FLS_UNC = 3;

  typedef enum logic [1:0] {
    OFS_ENABLE = 2'd0,
    OFS_STATUS = 2'd1,
    OFS_ADDR   = 2'd2,
    OFS_ATTR   = 2'd3
  } reg_ofs_e;

  // fixed priority: RAM unc > flash unc > RAM cor > flash cor
  function automatic logic [NUM_CAT-1:0] pick_winner(input logic [NUM_CAT-1:0] req);
    logic [NUM_CAT-1:0] w;
    w = '0;
    if (req[CAT_RAM_UNC])      w[CAT_RAM_UNC] = 1'b1;
    else if (req[CAT_FLS_UNC]) w[CAT_FLS_UNC] = 1'b1;
    else if (req[CAT_RAM_COR]) w[CAT_RAM_COR] = 1'b1;
    else if (req[CAT_FLS_COR]) w[CAT_FLS_COR] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_evt_arbiter.sv
module ecc_evt_arbiter
  import ecc_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input  logic [NUM_CAT-1:0] req,
  input  logic [ADDR_W-1:0]  ram_addr,
  input  logic [ATTR_W-1:0]  ram_attr,
  input  logic [ADDR_W-1:0]  fls_addr,
  input  logic [ATTR_W-1:0]  fls_attr,
  output logic               win_valid,
  output logic [NUM_CAT-1:0] win_onehot,
  output logic [ADDR_W-1:0]  win_addr,
  output logic [ATTR_W-1:0]  win_attr
);
  logic from_ram;

  always_comb begin
    win_onehot = pick_winner(req);
    win_valid  = |req;
    from_ram   = win_onehot[CAT_RAM_COR] | win_onehot[CAT_RAM_UNC];
    win_addr   = from_ram ? ram_addr : fls_addr;
    win_attr   = from_ram ? ram_attr : fls_attr;
  end
endmodule

// File: rtl/ecc_evt_status.sv
module ecc_evt_status
  import ecc_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_valid,
  input  logic [NUM_CAT-1:0] win_onehot,
  input  logic [ADDR_W-1:0]  win_addr,
  input  logic [ATTR_W-1:0]  win_attr,
  input  logic               clr_en,
  input  logic [NUM_CAT-1:0] clr_mask,
  output logic [NUM_CAT-1:0] flags,
  output logic [ADDR_W-1:0]  cap_addr,
  output logic [ATTR_W-1:0]  cap_attr
);
  logic [NUM_CAT-1:0] flags_d;
  logic               flags_ce;
  logic               cap_ce;

  // a new event replaces everything; a clear alone only drops bits
  always_comb begin
    cap_ce   = win_valid;
    flags_ce = win_valid | clr_en;
    if (win_valid) flags_d = win_onehot;
    else           flags_d = flags & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_ce) flags <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_attr <= '0;
    end else if (cap_ce) begin
      cap_addr <= win_addr;
      cap_attr <= win_attr;
    end
  end
endmodule

// File: rtl/ecc_irq_combine.sv
module ecc_irq_combine
  import ecc_rpt_pkg::*;
(
  input  logic [NUM_CAT-1:0] flags,
  input  logic [NUM_CAT-1:0] en,
  output logic               irq_single,
  output logic               irq_ram_unc,
  output logic               irq_fls_unc,
  output logic               irq_unc,
  output logic               irq_any
);
  logic [NUM_CAT-1:0] live;

  always_comb begin
    live        = flags & en;
    irq_single  = live[CAT_RAM_COR] | live[CAT_FLS_COR];
    irq_ram_unc = live[CAT_RAM_UNC];
    irq_fls_unc = live[CAT_FLS_UNC];
    irq_unc     = irq_ram_unc | irq_fls_unc;
    irq_any     = irq_single | irq_unc;
  end
endmodule

// File: rtl/ecc_evt_reporter.sv
module ecc_evt_reporter
  import ecc_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ram_cor_evt,
  input  logic              ram_unc_evt,
  input  logic [ADDR_W-1:0] ram_evt_addr,
  input  logic [ATTR_W-1:0] ram_evt_attr,
  input  logic              fls_cor_evt,
  input  logic              fls_unc_evt,
  input  logic [ADDR_W-1:0] fls_evt_addr,
  input  logic [ATTR_W-1:0] fls_evt_attr,
  output logic              irq_single,
  output logic              irq_ram_unc,
  output logic              irq_fls_unc,
  output logic              irq_unc,
  output logic              irq_any
);
  localparam int PAD_CAT  = DATA_W - NUM_CAT;
  localparam int PAD_ADDR = DATA_W - ADDR_W;
  localparam int PAD_ATTR = DATA_W - ATTR_W;

  logic               rst_sync_n;
  logic [NUM_CAT-1:0] en_q;
  logic [NUM_CAT-1:0] en_d;
  logic               en_ce;
  logic [NUM_CAT-1:0] evt_raw;
  logic [NUM_CAT-1:0] evt_req;
  logic               clr_en;
  logic               win_valid;
  logic [NUM_CAT-1:0] win_onehot;
  logic [ADDR_W-1:0]  win_addr;
  logic [ATTR_W-1:0]  win_attr;
  logic [NUM_CAT-1:0] flags;
  logic [ADDR_W-1:0]  cap_addr;
  logic [ATTR_W-1:0]  cap_attr;

  ecc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    evt_raw = '0;
    evt_raw[CAT_RAM_COR] = ram_cor_evt;
    evt_raw[CAT_FLS_COR] = fls_cor_evt;
    evt_raw[CAT_RAM_UNC] = ram_unc_evt;
    evt_raw[CAT_FLS_UNC] = fls_unc_evt;
    evt_req = evt_raw & en_q;
    en_ce   = reg_wr && (reg_addr == OFS_ENABLE);
    en_d    = reg_wdata[NUM_CAT-1:0];
    clr_en  = reg_wr && (reg_addr == OFS_STATUS);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else if (en_ce)  en_q <= en_d;
  end

  ecc_evt_arbiter #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_arb (
    .req(evt_req),
    .ram_addr(ram_evt_addr), .ram_attr(ram_evt_attr),
    .fls_addr(fls_evt_addr), .fls_attr(fls_evt_attr),
    .win_valid(win_valid), .win_onehot(win_onehot),
    .win_addr(win_addr), .win_attr(win_attr)
  );

  ecc_evt_status #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_stat (
    .clk(clk), .rst_n(rst_sync_n),
    .win_valid(win_valid), .win_onehot(win_onehot),
    .win_addr(win_addr), .win_attr(win_attr),
    .clr_en(clr_en), .clr_mask(reg_wdata[NUM_CAT-1:0]),
    .flags(flags), .cap_addr(cap_addr), .cap_attr(cap_attr)
  );

  ecc_irq_combine u_irq (
    .flags(flags), .en(en_q),
    .irq_single(irq_single), .irq_ram_unc(irq_ram_unc),
    .irq_fls_unc(irq_fls_unc), .irq_unc(irq_unc), .irq_any(irq_any)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_ENABLE: reg_rdata = {{PAD_CAT{1'b0}}, en_q};
      OFS_STATUS: reg_rdata = {{PAD_CAT{1'b0}}, flags};
      OFS_ADDR:   reg_rdata = {{PAD_ADDR{1'b0}}, cap_addr};
      default:    reg_rdata = {{PAD_ATTR{1'b0}}, cap_attr};
    endcase
  end
endmodule

// File: rtl/ecc_rpt_chk.sv
module ecc_rpt_chk
  import ecc_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_CAT-1:0] evt_raw,
  input logic [NUM_CAT-1:0] en_q,
  input logic [NUM_CAT-1:0] flags,
  input logic [ADDR_W-1:0]  cap_addr,
  input logic [ATTR_W-1:0]  cap_attr,
  input logic               irq_single,
  input logic               irq_ram_unc,
  input logic               irq_fls_unc,
  input logic               irq_unc,
  input logic               irq_any
);
  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(flags));

  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((evt_raw & en_q) == '0) |=> ($stable(cap_addr) && $stable(cap_attr)));

  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((evt_raw & en_q) != '0) |=> ((flags & $past(evt_raw & en_q)) != '0));

  p_event_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (((evt_raw & en_q) != '0) && reg_wr && reg_addr == OFS_STATUS) |=> (flags != '0));

  p_prio_ram_unc_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_raw[CAT_RAM_UNC] && en_q[CAT_RAM_UNC]) |=> flags[CAT_RAM_UNC]);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == OFS_STATUS && ((evt_raw & en_q) == '0))
      |=> ((flags & $past(reg_wdata[NUM_CAT-1:0])) == '0));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_single == |(flags[1:0] & en_q[1:0]));

  p_unc_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_unc == |(flags[3:2] & en_q[3:2]));

  p_any_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_any == ((flags & en_q) != '0));

  p_ram_fls_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(irq_ram_unc && irq_fls_unc));
endmodule

bind ecc_evt_reporter ecc_rpt_chk #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_raw(evt_raw), .en_q(en_q), .flags(flags),
  .cap_addr(cap_addr), .cap_attr(cap_attr), .irq_single(irq_single),
  .irq_ram_unc(irq_ram_unc), .irq_fls_unc(irq_fls_unc), .irq_unc(irq_unc),
  .irq_any(irq_any)
);

// File: tb/ecc_evt_reporter_tb_top.sv
`timescale 1ns/1ps
module ecc_evt_reporter_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ram_cor_evt, ram_unc_evt, fls_cor_evt, fls_unc_evt;
  logic [31:0] ram_evt_addr, fls_evt_addr;
  logic [7:0]  ram_evt_attr, fls_evt_attr;
  logic        irq_single, irq_ram_unc, irq_fls_unc, irq_unc, irq_any;

  int checks;
  int errors;
  int cycles;

  logic [3:0]  m_en, m_flags;
  logic [31:0] m_addr;
  logic [7:0]  m_attr;

  ecc_evt_reporter dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endfunction

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] winner(input logic [3:0] r);
    if (r[2]) return 4'b0100;
    if (r[3]) return 4'b1000;
    if (r[0]) return 4'b0001;
    if (r[1]) return 4'b0010;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {28'd0, m_en};
      2'd1: return {28'd0, m_flags};
      2'd2: return m_addr;
      default: return {24'd0, m_attr};
    endcase
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic model_update();
    logic [3:0] req, w;
    req = {fls_unc_evt, ram_unc_evt, fls_cor_evt, ram_cor_evt} & m_en;
    w = winner(req);
    if (req != 4'd0) begin
      m_flags = w;
      m_addr  = (w[0] | w[2]) ? ram_evt_addr : fls_evt_addr;
      m_attr  = (w[0] | w[2]) ? ram_evt_attr : fls_evt_attr;
    end else if (reg_wr && reg_addr == 2'd1) begin
      m_flags = m_flags & ~reg_wdata[3:0];
    end
    if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[3:0];
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(2'd0, d); chk("R2 enable read", d, exp_read(2'd0));
    rd(2'd1, d); chk("R8 status read", d, exp_read(2'd1));
    rd(2'd2, d); chk("R9 address read", d, exp_read(2'd2));
    rd(2'd3, d); chk("R9 attribute read", d, exp_read(2'd3));
    chk("R5 irq_single", {31'd0, irq_single}, {31'd0, |(m_flags[1:0] & m_en[1:0])});
    chk("R6 irq_ram_unc", {31'd0, irq_ram_unc}, {31'd0, m_flags[2] & m_en[2]});
    chk("R6 irq_fls_unc", {31'd0, irq_fls_unc}, {31'd0, m_flags[3] & m_en[3]});
    chk("R6 irq_unc", {31'd0, irq_unc}, {31'd0, |(m_flags[3:2] & m_en[3:2])});
    chk("R7 irq_any", {31'd0, irq_any}, {31'd0, |(m_flags & m_en)});
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; reg_wdata = '0;
    ram_cor_evt = 1'b0; ram_unc_evt = 1'b0;
    fls_cor_evt = 1'b0; fls_unc_evt = 1'b0;
  endtask

  // inputs already driven on the falling edge; sample after the next one
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_inputs();
    check_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic evt(input logic [3:0] cats, input logic [31:0] ra, input logic [7:0] rt,
                     input logic [31:0] fa, input logic [7:0] ft);
    ram_cor_evt = cats[0]; fls_cor_evt = cats[1];
    ram_unc_evt = cats[2]; fls_unc_evt = cats[3];
    ram_evt_addr = ra; ram_evt_attr = rt;
    fls_evt_addr = fa; fls_evt_attr = ft;
  endtask

  initial begin
    logic [31:0] s1, s2, a1, t1;
    void'($urandom(32'h00c0ffee));
    checks = 0; errors = 0;
    m_en = '0; m_flags = '0; m_addr = '0; m_attr = '0;
    idle_inputs();
    reg_addr = '0;
    ram_evt_addr = '0; ram_evt_attr = '0; fls_evt_addr = '0; fls_evt_attr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, s1); chk("R1 enable after reset", s1, 32'd0);
    rd(2'd1, s1); chk("R1 status after reset", s1, 32'd0);
    rd(2'd2, s1); chk("R1 address after reset", s1, 32'd0);
    rd(2'd3, s1); chk("R1 attribute after reset", s1, 32'd0);
    chk("R1 irq_any after reset", {31'd0, irq_any}, 32'd0);

    // R4 disabled event ignored
    evt(4'b1111, 32'h1111_0000, 8'h11, 32'h2222_0000, 8'h22); step();
    rd(2'd1, s1); chk("R4 status after disabled event", s1, 32'd0);
    rd(2'd2, s1); chk("R4 address after disabled event", s1, 32'd0);

    // R2 upper bits of enable ignored
    wr(2'd0, 32'hFFFF_FFFF); step();
    rd(2'd0, s1); chk("R2 enable upper bits", s1, 32'h0000_000F);

    // R3 R5 RAM corrected
    evt(4'b0001, 32'hA000_0010, 8'h5A, 32'hB000_0020, 8'hA5); step();
    rd(2'd1, s1); chk("R3 RAM corrected flag bit 0", s1, 32'h1);
    chk("R5 irq_single set", {31'd0, irq_single}, 32'd1);

    // R8 R9 R6 R7 flash uncorrectable replaces
    evt(4'b1000, 32'hA000_0030, 8'h01, 32'hB000_0040, 8'h02); step();
    rd(2'd1, s1); chk("R8 replaced flag", s1, 32'h8);
    rd(2'd2, s1); chk("R9 flash address captured", s1, 32'hB000_0040);
    rd(2'd3, s1); chk("R9 flash attribute captured", s1, 32'h02);
    chk("R6 irq_fls_unc set", {31'd0, irq_fls_unc}, 32'd1);
    chk("R7 irq_any set", {31'd0, irq_any}, 32'd1);
    chk("R5 irq_single cleared by replacement", {31'd0, irq_single}, 32'd0);

    // R10 W1C
    wr(2'd1, 32'hFFFF_FFF1); step();
    rd(2'd1, s1); chk("R10 write to clear bits no effect", s1, 32'h8);
    wr(2'd1, 32'h0000_0000); step();
    rd(2'd1, s1); chk("R10 write zero no effect", s1, 32'h8);
    wr(2'd1, 32'h0000_0008); step();
    rd(2'd1, s1); chk("R10 w1c clears", s1, 32'h0);
    chk("R7 irq_any low after clear", {31'd0, irq_any}, 32'd0);

    // R11 event beats clear
    evt(4'b0010, 32'h0, 8'h0, 32'hB000_0050, 8'h33); step();
    evt(4'b0100, 32'hA000_0060, 8'h44, 32'h0, 8'h0); wr(2'd1, 32'hF); step();
    rd(2'd1, s1); chk("R11 event beats clear", s1, 32'h4);
    rd(2'd2, s1); chk("R11 capture loaded", s1, 32'hA000_0060);

    // R12 priority
    evt(4'b1111, 32'hA000_0070, 8'h55, 32'hB000_0070, 8'h66); step();
    rd(2'd1, s1); chk("R12 all four picks RAM unc", s1, 32'h4);
    evt(4'b1010, 32'hA000_0080, 8'h77, 32'hB000_0080, 8'h88); step();
    rd(2'd1, s1); chk("R12 flash unc over flash cor", s1, 32'h8);
    evt(4'b0011, 32'hA000_0090, 8'h99, 32'hB000_0090, 8'hAA); step();
    rd(2'd1, s1); chk("R12 RAM cor over flash cor", s1, 32'h1);
    rd(2'd3, s1); chk("R12 winner attribute", s1, 32'h99);

    // R5 enable gates the interrupt but not the flag
    wr(2'd0, 32'h0000_000E); step();
    rd(2'd1, s1); chk("R5 flag kept when enable drops", s1, 32'h1);
    chk("R5 irq_single gated off", {31'd0, irq_single}, 32'd0);
    evt(4'b0001, 32'hDEAD_0000, 8'hEE, 32'h0, 8'h0); step();
    rd(2'd2, s1); chk("R4 disabled category no capture", s1, 32'hA000_0090);
    wr(2'd0, 32'hF); step();

    // R13 coherent read sequence
    @(negedge clk);
    rd(2'd1, s1); rd(2'd2, a1); rd(2'd3, t1); rd(2'd1, s2);
    chk("R13 status reread matches", s2, s1);
    rd(2'd1, s1); rd(2'd2, a1); rd(2'd3, t1);
    evt(4'b1000, 32'h0, 8'h0, 32'hB000_00F0, 8'h0F); step();
    rd(2'd1, s2);
    checks++;
    if (s2 === s1) begin
      errors++;
      $display("FAIL R13 status reread: actual %h expected change from %h", s2, s1);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      if (r < 40) evt(4'($urandom_range(0, 15)), $urandom, 8'($urandom), $urandom, 8'($urandom));
      r = $urandom_range(0, 99);
      if (r < 10) wr(2'd0, $urandom);
      else if (r < 35) wr(2'd1, $urandom);
      else if (r < 40) wr(2'($urandom_range(2, 3)), $urandom);
      step();
    end

    summary();
    $finish;
  end
endmodule